// File: doc/BRIEF.md
# Floppy Data-Rate Select Register

This block is the write-side control register a floppy disk controller uses to pick its transfer rate and its write precompensation. It also provides a manual low-power request and a software reset that clears itself. A CPU writes one byte over a simple register strobe. The block keeps each field and presents it to the controller core:

- the rate as a one-hot select, next to the raw 2-bit code;
- the 3-bit precompensation code;
- a low-power flag;
- a soft-reset pulse that lasts one clock.

A read-only shadow byte mirrors the held value, so software can see a register it cannot read directly. Each field has its own reset and clearing rule:

- A hardware reset puts the rate at the 250 Kbps code.
- The software reset leaves the rate as it is.
- Low power ends on the software reset, or on an access to the controller's data register or main status register. Those accesses arrive as two input strobes.

Top module: `fdc_rate_sel`

## Requirements
- R1: While `rstN` is low, the outputs are: rateCode = 2'b10 (250 Kbps), rateOneHot = 4'b0100, precompCode = 0, lowPower = 0, softResetPulse = 0, shadowData = 8'h02.
- R2: A write (`wrEn` high at a clock edge) loads wrData[1:0] into rateCode after that edge, and rateOneHot then has only bit number rateCode set, for each of the four codes.
- R3: A write loads wrData[4:2] into precompCode after that edge.
- R4: shadowData is {bit7 = reset bit, bit6 = low power, bit5 = 0, bits4:2 = precomp, bits1:0 = rate}, and bit 5 reads 0 whatever value was written to it.
- R5: A write with wrData[7] = 1 makes softResetPulse high for exactly the one cycle after the write. shadowData[7] is 1 in that cycle and 0 in the cycle after it, unless another such write follows.
- R6: The software reset does not change the rate code: after the pulse, rateCode keeps the value loaded by that write and does not return to 2'b10.
- R7: A write with wrData[6] = 1 and wrData[7] = 0 sets lowPower after the edge.
- R8: `dataRegAccess` or `statusRegAccess` high at an edge without a write clears lowPower after that edge. When a write lands in the same cycle, the written value wins.
- R9: A write with wrData[7] = 1 leaves lowPower at 0 even if wrData[6] = 1.
- R10: Without a write, rateCode and precompCode hold their values across cycles and across data or status accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, asynchronous, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data byte |
| dataRegAccess | input | 1 | Strobe: CPU accessed the data register |
| statusRegAccess | input | 1 | Strobe: CPU accessed the main status register |
| rateCode | output | 2 | Held data-rate code |
| rateOneHot | output | 4 | Decoded rate select, one bit per code |
| precompCode | output | 3 | Held write-precompensation code |
| lowPower | output | 1 | Manual low-power request |
| softResetPulse | output | 1 | One-cycle soft reset to the controller core |
| shadowData | output | 8 | Read-only mirror of the register |

## Verification
The bench builds the block with its default parameters: a 2-bit rate field, a 3-bit precompensation field and a hardware-reset rate code of 2'b10. With this byte layout, every field position the requirements name can be driven from the write bus. It also lets all four rate decodes and the reset-default decode be observed. Under these values the bench reaches every low-power exit path, including a write and an access in the same cycle, and a software reset combined with a low-power request.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // take a full register write
    logic wake;   // leave manual low power
  } rate_strobe_t;
endpackage

// File: rtl/fdc_rate_ctrl.sv
module fdc_rate_ctrl
  import fdc_rate_pkg::*;
(
  input  logic         wrEn,
  input  logic         dataRegAccess,
  input  logic         statusRegAccess,
  output rate_strobe_t strobes
);
  // A write in the same cycle takes priority over the wake-up accesses
  always_comb begin
    strobes.load = wrEn;
    strobes.wake = (dataRegAccess | statusRegAccess) & ~wrEn;
  end
endmodule

// File: rtl/fdc_rate_dp.sv
module fdc_rate_dp
  import fdc_rate_pkg::*;
#(
  parameter int RATE_W = 2,
  parameter int PRE_W  = 3,
  parameter logic [RATE_W-1:0] RESET_RATE = 2'b10,
  localparam int DATA_W  = RATE_W + PRE_W + 3,
  localparam int RATE_N  = 1 << RATE_W,
  localparam int PRE_LSB = RATE_W,
  localparam int LP_BIT  = RATE_W + PRE_W + 1,
  localparam int SR_BIT  = RATE_W + PRE_W + 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  rate_strobe_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [RATE_W-1:0] rateCode,
  output logic [RATE_N-1:0] rateOneHot,
  output logic [PRE_W-1:0]  precompCode,
  output logic              lowPower,
  output logic              softResetPulse,
  output logic [DATA_W-1:0] shadowData
);
  logic [RATE_W-1:0] rateQ;
  logic [PRE_W-1:0]  preQ;
  logic              lpQ;
  logic              srQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= RESET_RATE;
      preQ  <= '0;
      lpQ   <= 1'b0;
      srQ   <= 1'b0;
    end else if (strobes.load) begin
      rateQ <= wrData[RATE_W-1:0];
      preQ  <= wrData[PRE_LSB +: PRE_W];
      srQ   <= wrData[SR_BIT];
      lpQ   <= wrData[LP_BIT] & ~wrData[SR_BIT];
    end else begin
      srQ <= 1'b0;
      if (strobes.wake) lpQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < RATE_N; i++) begin : g_dec
    assign rateOneHot[i] = (rateQ == RATE_W'(i));
  end

  assign rateCode       = rateQ;
  assign precompCode    = preQ;
  assign lowPower       = lpQ;
  assign softResetPulse = srQ;
  assign shadowData     = {srQ, lpQ, 1'b0, preQ, rateQ};
endmodule

// File: rtl/fdc_rate_sel.sv
module fdc_rate_sel
  import fdc_rate_pkg::*;
#(
  parameter int RATE_W = 2,
  parameter int PRE_W  = 3,
  parameter logic [RATE_W-1:0] RESET_RATE = 2'b10,
  localparam int DATA_W = RATE_W + PRE_W + 3,
  localparam int RATE_N = 1 << RATE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataRegAccess,
  input  logic              statusRegAccess,
  output logic [RATE_W-1:0] rateCode,
  output logic [RATE_N-1:0] rateOneHot,
  output logic [PRE_W-1:0]  precompCode,
  output logic              lowPower,
  output logic              softResetPulse,
  output logic [DATA_W-1:0] shadowData
);
  rate_strobe_t strobes;

  fdc_rate_ctrl u_ctrl (
    .wrEn            (wrEn),
    .dataRegAccess   (dataRegAccess),
    .statusRegAccess (statusRegAccess),
    .strobes         (strobes)
  );

  fdc_rate_dp #(
    .RATE_W     (RATE_W),
    .PRE_W      (PRE_W),
    .RESET_RATE (RESET_RATE)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .wrData         (wrData),
    .rateCode       (rateCode),
    .rateOneHot     (rateOneHot),
    .precompCode    (precompCode),
    .lowPower       (lowPower),
    .softResetPulse (softResetPulse),
    .shadowData     (shadowData)
  );
endmodule

// File: rtl/fdc_rate_chk.sv
module fdc_rate_chk #(
  parameter int RATE_W = 2,
  parameter int PRE_W  = 3,
  localparam int DATA_W = RATE_W + PRE_W + 3,
  localparam int RATE_N = 1 << RATE_W,
  localparam int PRE_LSB = RATE_W,
  localparam int RSV_BIT = RATE_W + PRE_W,
  localparam int SR_BIT  = RATE_W + PRE_W + 2
)(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              dataRegAccess,
  input logic              statusRegAccess,
  input logic [RATE_W-1:0] rateCode,
  input logic [RATE_N-1:0] rateOneHot,
  input logic [PRE_W-1:0]  precompCode,
  input logic              lowPower,
  input logic              softResetPulse,
  input logic [DATA_W-1:0] shadowData
);
  assert_onehot_rate_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(rateOneHot) == 1) && rateOneHot[rateCode]);

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (precompCode == $past(wrData[PRE_LSB +: PRE_W])) && !shadowData[RSV_BIT]);

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |-> $past(wrEn && wrData[SR_BIT]));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |=> (!softResetPulse || $past(wrEn && wrData[SR_BIT])));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((dataRegAccess || statusRegAccess) && !wrEn) |=> !lowPower);

  assert_sr_no_lp_R9: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |-> !lowPower);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(rateCode) && $stable(precompCode)));
endmodule

bind fdc_rate_sel fdc_rate_chk #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_chk (.*);

// File: tb/tb_fdc_rate_sel.sv
module tb_fdc_rate_sel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       dataRegAccess = 1'b0;
  logic       statusRegAccess = 1'b0;
  logic [1:0] rateCode;
  logic [3:0] rateOneHot;
  logic [2:0] precompCode;
  logic       lowPower;
  logic       softResetPulse;
  logic [7:0] shadowData;

  always #2.5 clk = ~clk;

  fdc_rate_sel dut (.*);

  typedef struct {
    logic [3:0] oneHot;
    logic [2:0] pre;
    logic       lp;
    logic       pulse;
    logic [7:0] shadow;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int vecCount = 0;
  int failCount = 0;
  bit done = 0;

  // Reference state built from the requirements
  logic [1:0] mRate = 2'b10;
  logic [2:0] mPre = '0;
  logic       mLp = 0;
  logic       mRb = 0;

  task automatic apply(input logic rst, input logic wr, input logic [7:0] d,
                       input logic dacc, input logic sacc, input string tag);
    exp_t e;
    @(negedge clk);
    rstN = rst; wrEn = wr; wrData = d;
    dataRegAccess = dacc; statusRegAccess = sacc;
    if (!rst) begin
      mRate = 2'b10; mPre = '0; mLp = 0; mRb = 0;
    end else if (wr) begin
      mRate = d[1:0]; mPre = d[4:2]; mRb = d[7]; mLp = d[6] & ~d[7];
    end else begin
      mRb = 0;
      if (dacc | sacc) mLp = 0;
    end
    e.oneHot = 4'b0001 << mRate;
    e.pre = mPre; e.lp = mLp; e.pulse = mRb;
    e.shadow = {mRb, mLp, 1'b0, mPre, mRate};
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: sample shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        vecCount++;
        if (rateOneHot !== e.oneHot || precompCode !== e.pre || lowPower !== e.lp ||
            softResetPulse !== e.pulse || shadowData !== e.shadow) begin
          failCount++;
          $display("FAIL %s: got oneHot=%b pre=%0d lp=%b pulse=%b shadow=%h, expected oneHot=%b pre=%0d lp=%b pulse=%b shadow=%h",
                   e.tag, rateOneHot, precompCode, lowPower, softResetPulse, shadowData,
                   e.oneHot, e.pre, e.lp, e.pulse, e.shadow);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    apply(0, 0, 8'h00, 0, 0, "R1 reset");
    apply(0, 1, 8'hFF, 1, 1, "R1 reset held");
    apply(1, 0, 8'h00, 0, 0, "R1 after release");
    apply(1, 1, 8'h00, 0, 0, "R2 rate 00");
    apply(1, 1, 8'h01, 0, 0, "R2 rate 01");
    apply(1, 1, 8'h03, 0, 0, "R2 rate 11");
    apply(1, 1, 8'h02, 0, 0, "R2 rate 10");
    apply(1, 1, 8'h1C, 0, 0, "R3 precomp 7");
    apply(1, 1, 8'h15, 0, 0, "R3 precomp 5");
    apply(1, 1, 8'h3F, 0, 0, "R4 bit5 written 1");
    apply(1, 1, 8'h20, 0, 0, "R4 bit5 only");
    apply(1, 1, 8'h81, 0, 0, "R5 pulse");
    apply(1, 0, 8'h00, 0, 0, "R5 pulse clears");
    apply(1, 0, 8'h00, 0, 0, "R5 stays clear");
    apply(1, 1, 8'h8F, 0, 0, "R6 soft reset write");
    apply(1, 0, 8'h00, 0, 0, "R6 rate kept");
    apply(1, 0, 8'h00, 0, 0, "R6 rate kept later");
    apply(1, 1, 8'h40, 0, 0, "R7 low power set");
    apply(1, 0, 8'h00, 0, 0, "R7 low power held");
    apply(1, 0, 8'h00, 1, 0, "R8 data access wakes");
    apply(1, 1, 8'h49, 0, 0, "R7 low power again");
    apply(1, 0, 8'h00, 0, 1, "R8 status access wakes");
    apply(1, 1, 8'h42, 1, 0, "R8 write wins over access");
    apply(1, 0, 8'h00, 0, 0, "R8 still low power");
    apply(1, 0, 8'h00, 1, 1, "R8 both accesses wake");
    apply(1, 1, 8'hC1, 0, 0, "R9 reset with low power");
    apply(1, 0, 8'h00, 0, 0, "R9 after pulse");
    apply(1, 1, 8'h17, 0, 0, "R10 load");
    apply(1, 0, 8'h00, 1, 0, "R10 hold data access");
    apply(1, 0, 8'h00, 0, 1, "R10 hold status access");
    apply(1, 0, 8'hFF, 0, 0, "R10 hold idle bus");
    apply(1, 1, 8'h81, 0, 0, "R5 back-to-back first");
    apply(1, 1, 8'h80, 0, 0, "R5 back-to-back second");
    apply(1, 0, 8'h00, 0, 0, "R5 back-to-back clears");
    apply(1, 1, 8'h5D, 0, 0, "R7 before hw reset");
    apply(0, 0, 8'h00, 0, 0, "R1 mid-run reset");
    apply(1, 0, 8'h00, 0, 0, "R1 after mid-run reset");
    while (expQ.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule